// File: doc/BRIEF.md
# Serial Command Byte Receiver

This block accepts command and data bytes from a host over a four-wire clocked serial link. The four wires are an active-low chip select, a serial clock, a serial data line and a register-select line. While chip select is low, each rising edge of the serial clock shifts one data bit into an internal shifter. The first bit received becomes the most significant bit of the byte. On the eighth rising edge the block forms the complete byte and captures the register-select level at that same edge. That level tags the byte as an instruction (0) or as data (1).

Capture happens in the serial-clock domain. The block then signals completion across to the system clock by flipping a toggle flag. A synchronizer and an edge detector turn each flip into a single-cycle valid pulse in the system-clock domain. Together with that pulse, the byte and its tag are copied into output registers. These registers keep their value until the next byte completes.

Raising chip select clears any partial byte and the bit counter. With chip select low, bytes may stream back to back: the ninth serial clock edge already carries the next byte's most significant bit.

Top module: `serial_cmd_rx`

## Requirements
- R1: After the asynchronous active-low reset, byte_valid, byte_out and byte_is_data are all 0.
- R2: byte_out holds the eight bits in arrival order, with the first bit received at bit 7 and the last at bit 0.
- R3: byte_is_data equals the level of reg_sel at the eighth rising serial clock edge of the byte (0 = instruction, 1 = data). The reg_sel level at the other seven edges has no effect.
- R4: Raising cs_n discards a partially received byte and clears the bit counter. The first rising edge after cs_n falls again carries bit 7 of a new byte.
- R5: Serial clock edges while cs_n is high produce no byte and no valid pulse.
- R6: With cs_n held low, the ninth, seventeenth and following edges start a new byte with no gap, and every completed byte is delivered.
- R7: Each completed byte produces exactly one byte_valid pulse that lasts a single system clock cycle.
- R8: byte_out and byte_is_data change only in the cycle in which byte_valid is high, and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| cs_n | input | 1 | Active-low chip select; when high, clears the shifter and the bit counter |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| reg_sel | input | 1 | Register select, sampled on the eighth edge (0 instruction, 1 data) |
| byte_valid | output | 1 | One-cycle pulse in the clk domain when a byte is delivered |
| byte_out | output | BITS | Last delivered byte |
| byte_is_data | output | 1 | Tag of the last delivered byte |

## Verification
The hardest case to reach from the ports is a byte that is cut off partway by chip select. The shifter and counter must forget those bits, and the captured output must not move. The stimulus drives five bits, raises chip select, and keeps toggling the serial clock while chip select is high. It then lowers chip select again and sends a full byte. The scoreboard expects only that last byte. It also expects the tag to follow reg_sel at the eighth edge, because the bench drives the opposite level at every other edge. A later run streams several bytes without releasing chip select, which checks that the counter wraps correctly.

// File: rtl/serrx_pkg.sv
`timescale 1ns/1ps
package serrx_pkg;
   localparam int DEF_BITS        = 8;
   localparam int DEF_SYNC_STAGES = 2;

   typedef enum logic {
      SEL_INSTR = 1'b0,
      SEL_DATA  = 1'b1
   } sel_kind_e;

   function automatic int cnt_width(input int bits);
      return (bits <= 2) ? 1 : $clog2(bits);
   endfunction
endpackage

// File: rtl/serrx_shift.sv
`timescale 1ns/1ps
module serrx_shift
   import serrx_pkg::*;
#(
   parameter int BITS = DEF_BITS
) (
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            sclk,
   input  logic            sdata,
   input  logic            reg_sel,
   input  logic            clk,
   output logic [BITS-1:0] cap_byte,
   output sel_kind_e       cap_kind,
   output logic            cap_tgl
);
   localparam int              CW   = cnt_width(BITS);
   localparam logic [CW-1:0]   LAST = CW'(BITS - 1);

   generate
      if (BITS < 2) begin : g_bad_bits
         $error("serrx_shift: BITS must be at least 2");
      end
   endgenerate

   logic            clr;
   logic [BITS-1:0] sh_q;
   logic [CW-1:0]   cnt_q;
   logic            last_bit;
   logic [BITS-1:0] full_word;

   assign clr       = ~rst_n | cs_n;
   assign last_bit  = (cnt_q == LAST);
   assign full_word = {sh_q[BITS-2:0], sdata};

   // shifter and bit counter, cleared while chip select is high
   always_ff @(posedge sclk or posedge clr) begin
      if (clr) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else begin
         sh_q  <= full_word;
         cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
      end
   end

   // capture registers, cleared only by the system reset
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         cap_byte <= '0;
         cap_kind <= SEL_INSTR;
         cap_tgl  <= 1'b0;
      end else if (!cs_n && last_bit) begin
         cap_byte <= full_word;
         cap_kind <= sel_kind_e'(reg_sel);
         cap_tgl  <= ~cap_tgl;
      end
   end

   // R4
   property p_cnt_clear;
      @(posedge clk) disable iff (!rst_n) cs_n |-> (cnt_q == '0);
   endproperty
   cnt_clear_chk: assert property (p_cnt_clear);

   // R6
   property p_cnt_wrap;
      @(posedge sclk) disable iff (clr) (cnt_q == LAST) |=> (cnt_q == '0);
   endproperty
   cnt_wrap_chk: assert property (p_cnt_wrap);

   // R3
   property p_sel_capture;
      @(posedge sclk) disable iff (clr)
         (cnt_q == LAST) |=> (cap_kind == sel_kind_e'($past(reg_sel)));
   endproperty
   sel_capture_chk: assert property (p_sel_capture);
endmodule

// File: rtl/serrx_sync.sv
`timescale 1ns/1ps
module serrx_sync
   import serrx_pkg::*;
#(
   parameter int STAGES = DEF_SYNC_STAGES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serrx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_async;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/serrx_pulse.sv
`timescale 1ns/1ps
module serrx_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign pulse = lvl ^ lvl_q;
endmodule

// File: rtl/serial_cmd_rx.sv
`timescale 1ns/1ps
module serial_cmd_rx
   import serrx_pkg::*;
#(
   parameter int BITS        = DEF_BITS,
   parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            sclk,
   input  logic            sdata,
   input  logic            reg_sel,
   output logic            byte_valid,
   output logic [BITS-1:0] byte_out,
   output logic            byte_is_data
);
   logic [BITS-1:0] cap_byte;
   sel_kind_e       cap_kind;
   logic            cap_tgl;
   logic            tgl_sync;
   logic            done_pulse;

   serrx_shift #(.BITS(BITS)) u_shift (
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdata    (sdata),
      .reg_sel  (reg_sel),
      .clk      (clk),
      .cap_byte (cap_byte),
      .cap_kind (cap_kind),
      .cap_tgl  (cap_tgl)
   );

   serrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (cap_tgl),
      .q_sync  (tgl_sync)
   );

   serrx_pulse u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (tgl_sync),
      .pulse (done_pulse)
   );

   // capture registers stay put for many system cycles after a toggle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_valid   <= 1'b0;
         byte_out     <= '0;
         byte_is_data <= 1'b0;
      end else begin
         byte_valid <= done_pulse;
         if (done_pulse) begin
            byte_out     <= cap_byte;
            byte_is_data <= (cap_kind == SEL_DATA);
         end
      end
   end

   // R7
   property p_one_cycle;
      @(posedge clk) disable iff (!rst_n) byte_valid |=> !byte_valid;
   endproperty
   valid_one_cycle_chk: assert property (p_one_cycle);

   // R8
   property p_hold;
      @(posedge clk) disable iff (!rst_n)
         !byte_valid |-> ($stable(byte_out) && $stable(byte_is_data));
   endproperty
   hold_stable_chk: assert property (p_hold);
endmodule

// File: tb/serial_cmd_rx_bench.sv
`timescale 1ns/1ps
module serial_cmd_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdata = 1'b0;
   logic       reg_sel = 1'b0;
   logic       byte_valid;
   logic [7:0] byte_out;
   logic       byte_is_data;

   int checks = 0;
   int fails  = 0;
   int pushed = 0;
   int seen   = 0;
   logic [8:0] exp_q[$];

   always #2.5 clk = ~clk;

   serial_cmd_rx u_serial_cmd_rx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
      .reg_sel(reg_sel), .byte_valid(byte_valid), .byte_out(byte_out),
      .byte_is_data(byte_is_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic sclk_edge();
      #10 sclk = 1'b1;
      #20 sclk = 1'b0;
      #10;
   endtask

   // drives a full byte; reg_sel is rs_last on the eighth edge, rs_other elsewhere
   task automatic send_byte(input logic [7:0] b, input logic rs_last, input logic rs_other);
      for (int i = 7; i >= 0; i--) begin
         sdata   = b[i];
         reg_sel = (i == 0) ? rs_last : rs_other;
         if (i == 0) begin
            exp_q.push_back({rs_last, b});
            pushed++;
         end
         sclk_edge();
      end
   endtask

   task automatic settle();
      repeat (30) @(posedge clk);
   endtask

   // monitor: pop and compare on each valid pulse (R2, R3, R7, R8)
   logic       prev_valid = 1'b0;
   logic [7:0] last_out = 8'h00;
   logic       last_tag = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_valid && byte_valid) begin
            fails++;
            $display("FAIL R7 actual=valid_two_cycles expected=one_cycle");
         end
         if (!byte_valid && (byte_out !== last_out || byte_is_data !== last_tag)) begin
            fails++;
            $display("FAIL R8 actual=%0h expected=%0h", byte_out, last_out);
         end
         if (byte_valid) begin
            seen++;
            if (exp_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R5 actual=%0h expected=no_byte", byte_out);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               check(byte_out === e[7:0], "R2 byte", int'(byte_out), int'(e[7:0]));
               check(byte_is_data === e[8], "R3 tag", int'(byte_is_data), int'(e[8]));
            end
         end
      end
      prev_valid = byte_valid;
      last_out   = byte_out;
      last_tag   = byte_is_data;
   end

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      // R1
      check(byte_valid === 1'b0, "R1 valid", int'(byte_valid), 0);
      check(byte_out === 8'h00, "R1 byte", int'(byte_out), 0);
      check(byte_is_data === 1'b0, "R1 tag", int'(byte_is_data), 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // R2 R3: single bytes, reg_sel opposite on the other seven edges
      cs_n = 1'b0; #10;
      send_byte(8'hA5, 1'b1, 1'b0);
      cs_n = 1'b1; settle();
      cs_n = 1'b0; #10;
      send_byte(8'h3C, 1'b0, 1'b1);
      cs_n = 1'b1; settle();

      // R5: sclk toggles with chip select high
      for (int k = 0; k < 16; k++) begin
         sdata = k[0]; reg_sel = 1'b1;
         sclk_edge();
      end
      settle();
      check(byte_out === 8'h3C, "R5 byte unchanged", int'(byte_out), 8'h3C);

      // R4: partial byte aborted by chip select
      cs_n = 1'b0; #10;
      for (int k = 0; k < 5; k++) begin
         sdata = 1'b1; reg_sel = 1'b1;
         sclk_edge();
      end
      cs_n = 1'b1; settle();
      check(byte_out === 8'h3C, "R4 partial dropped", int'(byte_out), 8'h3C);
      cs_n = 1'b0; #10;
      send_byte(8'h81, 1'b1, 1'b0);
      cs_n = 1'b1; settle();
      check(byte_out === 8'h81, "R4 restart at bit 7", int'(byte_out), 8'h81);

      // R6: streaming without releasing chip select
      cs_n = 1'b0; #10;
      send_byte(8'h01, 1'b0, 1'b1);
      send_byte(8'hFE, 1'b1, 1'b0);
      send_byte(8'h80, 1'b1, 1'b1);
      send_byte(8'h7F, 1'b0, 1'b0);
      send_byte(8'h00, 1'b1, 1'b0);
      cs_n = 1'b1; settle();

      // R6 R7: every byte delivered exactly once
      check(seen == pushed, "R7 pulse count", seen, pushed);
      check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
      check(byte_valid === 1'b0, "R7 idle", int'(byte_valid), 0);
      check(byte_out === 8'h00 && byte_is_data === 1'b1, "R8 held last",
            int'({byte_is_data, byte_out}), 9'h100);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule